// File: doc/BRIEF.md
# Serial Register Bank with Interrupt Aggregation

This block is a serial-peripheral slave that lets a host processor reach a bank of 64 registers, each 24 bits wide. Every transaction is one full-duplex 32-bit frame. The host drives the chip select high, shifts in a direction flag, a 6-bit register address and 24 data bits, and shifts out the addressed register's contents in the data slot of that same frame. The serial clock, chip select and data input are oversampled and synchronised into the system clock domain. All state changes happen on system clock edges.

Two of the registers collect event flags. Each flag is set by a one-cycle pulse on a per-bit event input and is cleared by the host, which writes a one to that bit. Each of these flag registers has a mask register beside it. The interrupt output is a level that stays high while any flag is set and its mask bit is clear. One address returns a fixed identification word and ignores writes. The remaining registers are plain storage.

Top module: `spi_regbank`

## Requirements
- R1: After reset both mask registers (addresses 1 and 4) read 0xFFFFFF. Both flag registers (addresses 0 and 3) read 0. Every other storage register reads 0. The interrupt output is low.
- R2: A frame with bit 31 = 1 writes frame bits 23:0 into the register selected by frame bits 30:25. The write takes effect only when the 32nd bit is received.
- R3: In every frame the slave drives MISO bit 31 first, in mode 0: it samples on rising SCLK and shifts on falling SCLK. Returned bits 31:24 are 0. Returned bits 23:0 hold the contents of the register named in bits 30:25 of that same frame. MISO is low while chip select is low.
- R4: If chip select falls before 32 bits have been received, no register changes.
- R5: In the flag registers (0 and 3), writing a 1 to a bit clears it and writing a 0 leaves it unchanged. A one-cycle pulse on the matching event input bit sets it.
- R6: If an event pulse and a write-one-to-clear hit the same flag bit in the same cycle, the bit ends up set.
- R7: The interrupt output is high exactly while some bit is set in flag register 0 with its bit clear in mask register 1, or set in flag register 3 with its bit clear in mask register 4. A mask bit of 1 suppresses its flag.
- R8: Address 7 reads the identification word and ignores writes. The word holds the minor revision in bits 2:0, the major revision in bits 4:3 and the IC code 2 in bits 8:6. Bits 12:9 hold the fab code, and all other bits are 0. With the default parameters (minor 2, major 3, fab 1) the word is 0x00029A.
- R9: All 64 addresses decode separately, from 0 through 63.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock, idle low |
| cs | input | 1 | Chip select, active high |
| mosi | input | 1 | Serial data from host |
| miso | output | 1 | Serial data to host |
| evt_a | input | 24 | Event pulses that set flags in register 0 |
| evt_b | input | 24 | Event pulses that set flags in register 3 |
| irq_o | output | 1 | Level interrupt, active high |

## Verification
The bench cuts frames short after 20 and after 31 bits. A design that commits on a partial count or keeps stale shift contents would corrupt the target register, so a later read-back catches it. It writes a zero to one flag bit while clearing a neighbour, which exposes a design that treats flag writes as plain stores. It holds an event high across a clearing frame, which exposes a design where the clear wins. It writes to the identification address and to the top address 63. A truncated address decoder or a writable identification word would show up as a wrong read-back. The interrupt is checked on both flag banks, with masks toggled while flags stay set, so a level that latches or ignores one bank is caught.

// File: rtl/spi_regbank.sv
module spi_regbank #(
  parameter int ADDR_W      = 6,
  parameter int DATA_W      = 24,
  parameter int FRAME_W     = 32,
  parameter int SYNC_STAGES = 2,
  parameter int REV_MINOR   = 2,
  parameter int REV_MAJOR   = 3,
  parameter int FAB_CODE    = 1,
  parameter int STAT_A      = 0,
  parameter int MASK_A      = 1,
  parameter int STAT_B      = 3,
  parameter int MASK_B      = 4,
  parameter int ID_ADDR     = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk,
  input  logic              cs,
  input  logic              mosi,
  output logic              miso,
  input  logic [DATA_W-1:0] evt_a,
  input  logic [DATA_W-1:0] evt_b,
  output logic              irq_o
);
  localparam int NREG      = 1 << ADDR_W;
  localparam int CNT_W     = $clog2(FRAME_W + 1);
  localparam int WR_BIT    = FRAME_W - 1;
  localparam int ADDR_DONE = 1 + ADDR_W;
  localparam logic [DATA_W-1:0] ID_WORD =
    DATA_W'({FAB_CODE[3:0], 3'd2, 1'b0, REV_MAJOR[1:0], REV_MINOR[2:0]});

  logic [SYNC_STAGES-1:0] sclk_sy, cs_sy, mosi_sy;
  logic                   sclk_d;
  logic [CNT_W-1:0]       cnt;
  logic [FRAME_W-1:0]     rx, tx;
  logic [DATA_W-1:0]      regs [NREG];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sclk_sy <= '0; cs_sy <= '0; mosi_sy <= '0; sclk_d <= 1'b0;
    end else begin
      sclk_sy <= {sclk_sy[SYNC_STAGES-2:0], sclk};
      cs_sy   <= {cs_sy[SYNC_STAGES-2:0], cs};
      mosi_sy <= {mosi_sy[SYNC_STAGES-2:0], mosi};
      sclk_d  <= sclk_sy[SYNC_STAGES-1];
    end

  wire sclk_s = sclk_sy[SYNC_STAGES-1];
  wire cs_s   = cs_sy[SYNC_STAGES-1];
  wire mosi_s = mosi_sy[SYNC_STAGES-1];
  wire rise   = sclk_s & ~sclk_d;
  wire fall   = ~sclk_s & sclk_d;

  wire [FRAME_W-1:0] frame_nx = {rx[FRAME_W-2:0], mosi_s};
  wire               wr_go    = cs_s && rise && (cnt == CNT_W'(FRAME_W - 1)) && frame_nx[WR_BIT];
  wire [ADDR_W-1:0]  wa       = frame_nx[FRAME_W-2 -: ADDR_W];
  wire [DATA_W-1:0]  wd       = frame_nx[DATA_W-1:0];

  wire [ADDR_W-1:0]  ra   = rx[ADDR_W-1:0];
  wire [DATA_W-1:0]  rd   = (ra == ADDR_W'(ID_ADDR)) ? ID_WORD : regs[ra];
  wire [FRAME_W-1:0] load = {{(FRAME_W-DATA_W){1'b0}}, rd} << ADDR_DONE;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cnt <= '0; rx <= '0; tx <= '0;
    end else if (!cs_s) begin
      cnt <= '0; rx <= '0; tx <= '0;
    end else begin
      if (rise && cnt != CNT_W'(FRAME_W)) begin
        rx  <= frame_nx;
        cnt <= cnt + 1'b1;
      end
      if (fall)
        tx <= (cnt == CNT_W'(ADDR_DONE)) ? load : (tx << 1);
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++)
        regs[i] <= (i == MASK_A || i == MASK_B) ? '1 : '0;
    end else begin
      for (int i = 0; i < NREG; i++) begin
        if (i == STAT_A)
          regs[i] <= (regs[i] & ~((wr_go && wa == ADDR_W'(i)) ? wd : '0)) | evt_a;
        else if (i == STAT_B)
          regs[i] <= (regs[i] & ~((wr_go && wa == ADDR_W'(i)) ? wd : '0)) | evt_b;
        else if (i != ID_ADDR && wr_go && wa == ADDR_W'(i))
          regs[i] <= wd;
      end
    end

  assign miso  = cs_s & tx[FRAME_W-1];
  assign irq_o = |((regs[STAT_A] & ~regs[MASK_A]) | (regs[STAT_B] & ~regs[MASK_B]));
endmodule

// File: rtl/spi_regbank_chk.sv
module spi_regbank_chk #(
  parameter int ADDR_W  = 6,
  parameter int DATA_W  = 24,
  parameter int CNT_W   = 6,
  parameter int FRAME_W = 32,
  parameter int STAT_A  = 0
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cs_s,
  input logic              miso,
  input logic              irq_o,
  input logic              wr_go,
  input logic [ADDR_W-1:0] wa,
  input logic [DATA_W-1:0] wd,
  input logic [CNT_W-1:0]  cnt,
  input logic [DATA_W-1:0] evt_a,
  input logic [DATA_W-1:0] st_a,
  input logic [DATA_W-1:0] mk_a,
  input logic [DATA_W-1:0] mk_b
);
  p_miso_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_s |-> !miso);

  p_count_cap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_W'(FRAME_W));

  p_abort_no_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_s |=> ($stable(mk_a) && $stable(mk_b)));

  p_w1c_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_go && wa == ADDR_W'(STAT_A) && wd[0] && !evt_a[0]) |=> !st_a[0]);

  p_event_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_a != '0) |=> ((st_a & $past(evt_a)) == $past(evt_a)));

  p_masked_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((&mk_a) && (&mk_b)) |-> !irq_o);
endmodule

bind spi_regbank spi_regbank_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .FRAME_W(FRAME_W), .STAT_A(STAT_A)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_s(cs_s), .miso(miso), .irq_o(irq_o),
  .wr_go(wr_go), .wa(wa), .wd(wd), .cnt(cnt), .evt_a(evt_a),
  .st_a(regs[STAT_A]), .mk_a(regs[MASK_A]), .mk_b(regs[MASK_B])
);

// File: tb/sim_spi_regbank.sv
module sim_spi_regbank;
  logic clk = 0, rst_n = 0, sclk = 0, cs = 0, mosi = 0;
  logic [23:0] evt_a = '0, evt_b = '0;
  logic miso, irq_o;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  spi_regbank u0 (.clk(clk), .rst_n(rst_n), .sclk(sclk), .cs(cs), .mosi(mosi),
                  .miso(miso), .evt_a(evt_a), .evt_b(evt_b), .irq_o(irq_o));

  task automatic wait_clk(int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic xfer(input logic [31:0] txw, output logic [31:0] rxw, input int nbits);
    rxw = '0;
    cs = 1; wait_clk(8);
    for (int i = 0; i < nbits; i++) begin
      mosi = txw[31-i];
      wait_clk(8);
      rxw[31-i] = miso;
      sclk = 1; wait_clk(8);
      sclk = 0;
    end
    wait_clk(8);
    cs = 0; mosi = 0; wait_clk(8);
  endtask

  task automatic wr(int a, logic [23:0] d);
    logic [31:0] r;
    xfer({1'b1, 6'(a), 1'b0, d}, r, 32);
  endtask

  task automatic rd(int a, output logic [31:0] r);
    xfer({1'b0, 6'(a), 25'b0}, r, 32);
  endtask

  task automatic t_reset;
    logic [31:0] r;
    chk("R1 irq", {31'b0, irq_o}, 0);
    rd(1, r);  chk("R1 mask a", r, 32'h00FFFFFF);
    rd(4, r);  chk("R1 mask b", r, 32'h00FFFFFF);
    rd(0, r);  chk("R1 flags a", r, 0);
    rd(3, r);  chk("R1 flags b", r, 0);
    rd(20, r); chk("R1 storage", r, 0);
  endtask

  task automatic t_rw;
    logic [31:0] r;
    wr(10, 24'hA5A5A5); wr(63, 24'h123456); wr(2, 24'h00FF00); wr(62, 24'h654321);
    rd(10, r); chk("R2 reg10", r, 32'h00A5A5A5);
    rd(63, r); chk("R9 reg63", r, 32'h00123456);
    rd(62, r); chk("R9 reg62", r, 32'h00654321);
    rd(2, r);  chk("R3 reg2 same-frame data, top byte zero", r, 32'h0000FF00);
    xfer({1'b1, 6'd2, 1'b0, 24'h111111}, r, 32);
    chk("R3 write frame returns old contents", r, 32'h0000FF00);
  endtask

  task automatic t_abort;
    logic [31:0] r;
    xfer({1'b1, 6'd10, 1'b0, 24'h0F0F0F}, r, 20);
    rd(10, r); chk("R4 abort after 20 bits", r, 32'h00A5A5A5);
    xfer({1'b1, 6'd10, 1'b0, 24'h0F0F0F}, r, 31);
    rd(10, r); chk("R4 abort after 31 bits", r, 32'h00A5A5A5);
  endtask

  task automatic t_id;
    logic [31:0] r;
    rd(7, r); chk("R8 id word", r, 32'h0000029A);
    wr(7, 24'hFFFFFF);
    rd(7, r); chk("R8 id ignores write", r, 32'h0000029A);
  endtask

  task automatic t_flags;
    logic [31:0] r;
    @(negedge clk) evt_a = 24'h000005;
    @(negedge clk) evt_a = '0;
    rd(0, r); chk("R5 event sets flags", r, 32'h00000005);
    chk("R7 masked flags keep irq low", {31'b0, irq_o}, 0);
    wr(0, 24'h000004);
    rd(0, r); chk("R5 write one clears, zero keeps", r, 32'h00000001);
    wr(1, 24'hFFFFFE); wait_clk(2);
    chk("R7 unmasked flag raises irq", {31'b0, irq_o}, 1);
    wr(0, 24'h000001); wait_clk(2);
    chk("R7 irq drops after clear", {31'b0, irq_o}, 0);
    rd(0, r); chk("R5 flags empty", r, 0);
  endtask

  task automatic t_bank_b;
    logic [31:0] r;
    @(negedge clk) evt_b = 24'h000020;
    @(negedge clk) evt_b = '0;
    wr(4, 24'hFFFFDF); wait_clk(2);
    chk("R7 bank b raises irq", {31'b0, irq_o}, 1);
    wr(4, 24'hFFFFFF); wait_clk(2);
    chk("R7 remask drops irq", {31'b0, irq_o}, 0);
    rd(3, r); chk("R5 bank b flag kept", r, 32'h00000020);
    wr(3, 24'h000020);
    rd(3, r); chk("R5 bank b cleared", r, 0);
  endtask

  task automatic t_event_wins;
    logic [31:0] r;
    @(negedge clk) evt_a = 24'h000002;
    wr(0, 24'h000002);
    @(negedge clk) evt_a = '0;
    rd(0, r); chk("R6 event beats clear", r, 32'h00000002);
    wr(0, 24'h000002);
    rd(0, r); chk("R6 later clear works", r, 0);
  endtask

  initial begin
    wait_clk(5); rst_n = 1; wait_clk(5);
    t_reset; t_rw; t_abort; t_id; t_flags; t_bank_b; t_event_wins;
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(5ns * 150000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule